// File: doc/BRIEF.md
# Inflight Packet Credit Release Unit

This block holds the inflight packet counts that a load balancer keeps for each of its buckets and each of its notification rings. Software returns credit by issuing a store whose address names a bucket, a ring and two enable bits, and whose data gives a packet count. On a valid release the count is subtracted from every enabled target in the same clock edge. A count never goes below zero: an oversized release clamps the count to zero and latches a sticky underflow flag, with one flag for buckets and one for rings.

A second port gives software direct access to the tables. It has a table select and an index. It can write a full bucket status entry, which holds an assigned ring, a reference count, a group and a mode. It can also write a ring counter. It can read either table back with one cycle of latency. A table write wins over a release to the same entry on the same edge.

Top module: `crr_credit_release`

## Requirements
- R1: After reset every bucket entry, every ring counter and both underflow flags are zero, and `tbl_rvalid` is low.
- R2: A store changes state only when `rel_valid` is high and address bits [28:26] equal 4. Any other region value has no effect on either table.
- R3: The address fields are placed as follows. The ring index is in bits [10:3] and the bucket index is in bits [23:11]. The ring enable is bit 24 and the bucket enable is bit 25. With only the bucket enable set, the release lowers only the bucket's reference count and leaves the other fields of the entry intact. With only the ring enable set, it lowers only the ring's counter.
- R4: With both enables set, the bucket and the ring are both decremented on the same edge. With neither set, the store has no effect.
- R5: The amount subtracted is `rel_count`. If it exceeds the current count, the count becomes zero.
- R6: A clamped bucket decrement sets `bkt_underflow` and a clamped ring decrement sets `ring_underflow`. Both flags hold until reset.
- R7: A table write with `tbl_sel`=0 stores a bucket entry in this layout: count in [15:0], ring in [23:16], group in [28:24], mode in [31:29]. With `tbl_sel`=1 it stores `tbl_wdata[15:0]` as a ring counter. Any other select value is ignored, and so is any index at or above the table depth.
- R8: A table read returns `tbl_rdata` with `tbl_rvalid` high on the cycle after the request. The value is the one stored before that edge. Ring values are zero-extended. An out-of-range index or another select value reads as 0.
- R9: A table write and a release that target the same entry on the same edge leave the written value in place. The other target of that release is still decremented.
- R10: A release to a bucket index at or above `BKT_DEPTH` (256) has no effect. In particular it does not alias onto a lower entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rel_valid | input | 1 | Release store strobe |
| rel_addr | input | 26 | Store address bits [28:3] |
| rel_count | input | 16 | Packets released |
| tbl_valid | input | 1 | Table access strobe |
| tbl_write | input | 1 | 1 = write, 0 = read |
| tbl_sel | input | 2 | 0 = bucket table, 1 = ring table |
| tbl_idx | input | 13 | Table entry index |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data |
| tbl_rvalid | output | 1 | Read data valid |
| bkt_underflow | output | 1 | Sticky bucket clamp flag |
| ring_underflow | output | 1 | Sticky ring clamp flag |

## Verification
The bench targets these corner cases:
- A write and a release that collide on one entry. A design that lets the release win returns the written count minus the release.
- A bucket index just past the table depth. A design that truncates the index decrements a low entry instead.
- Releases larger than the count. A wrapping subtractor yields a value near 65535 and leaves the flag low.
- Region codes other than 4, and stores with neither enable set. A design that skips the gate changes counts that should stay fixed.

Random mixes of releases and table writes over a small index range force frequent collisions. A read model in the bench checks every entry it touches.

// File: rtl/crr_pkg.sv
package crr_pkg;
  localparam int CNT_W      = 16;
  localparam int ENTRY_W    = 32;
  localparam int TBL_IDX_W  = 13;
  localparam int RING_IDX_W = 8;
  localparam int REGION_W   = 3;
  localparam logic [REGION_W-1:0] REL_REGION = 3'd4;

  typedef enum logic [1:0] {
    SEL_BUCKET = 2'd0,
    SEL_RING   = 2'd1
  } tbl_sel_e;

  typedef struct packed {
    logic                  ring_req;
    logic                  bkt_req;
    logic [RING_IDX_W-1:0] ring_idx;
    logic [TBL_IDX_W-1:0]  bkt_idx;
  } rel_cmd_t;

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] cur,
                                               input logic [CNT_W-1:0] amt);
    return (amt > cur) ? '0 : cur - amt;
  endfunction

  function automatic logic clamps(input logic [CNT_W-1:0] cur,
                                  input logic [CNT_W-1:0] amt);
    return amt > cur;
  endfunction
endpackage

// File: rtl/crr_rel_decode.sv
module crr_rel_decode
  import crr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rel_valid,
  input  logic [28:3]          rel_addr,
  output rel_cmd_t             cmd
);
  logic region_hit;

  assign region_hit   = (rel_addr[28:26] == REL_REGION);
  assign cmd.ring_idx = rel_addr[10:3];
  assign cmd.bkt_idx  = rel_addr[23:11];
  assign cmd.ring_req = rel_valid & region_hit & rel_addr[24];
  assign cmd.bkt_req  = rel_valid & region_hit & rel_addr[25];

  // R2: a request is never raised without a store strobe
  a_r2_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.bkt_req || cmd.ring_req) |-> rel_valid);
endmodule

// File: rtl/crr_count_bank.sv
module crr_count_bank #(
  parameter int DEPTH   = 256,
  parameter int IDX_W   = crr_pkg::TBL_IDX_W,
  parameter int ENTRY_W = crr_pkg::ENTRY_W,
  parameter int CNT_W   = crr_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               dec_req,
  input  logic [IDX_W-1:0]   dec_idx,
  input  logic [CNT_W-1:0]   dec_amt,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               dec_done,
  output logic               dec_sat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic               wr_in, dec_in, rd_in, wr_ok, collide;
  logic [AW-1:0]      wr_a, dec_a, rd_a;
  logic [ENTRY_W-1:0] cur_entry, next_entry;
  logic [CNT_W-1:0]   cur_cnt, next_cnt;

  generate
    if (DEPTH < (1 << IDX_W)) begin : g_range
      assign wr_in  = (wr_idx  < IDX_W'(DEPTH));
      assign dec_in = (dec_idx < IDX_W'(DEPTH));
      assign rd_in  = (rd_idx  < IDX_W'(DEPTH));
    end else begin : g_full
      assign wr_in  = 1'b1;
      assign dec_in = 1'b1;
      assign rd_in  = 1'b1;
    end
  endgenerate

  assign wr_a  = wr_idx[AW-1:0];
  assign dec_a = dec_idx[AW-1:0];
  assign rd_a  = rd_idx[AW-1:0];

  assign wr_ok    = wr_en & wr_in;
  assign collide  = wr_ok & (wr_idx == dec_idx);
  assign dec_done = dec_req & dec_in & ~collide;

  assign cur_entry = mem[dec_a];
  assign cur_cnt   = cur_entry[CNT_W-1:0];
  assign next_cnt  = crr_pkg::sat_sub(cur_cnt, dec_amt);
  assign dec_sat   = dec_done & crr_pkg::clamps(cur_cnt, dec_amt);

  generate
    if (ENTRY_W > CNT_W) begin : g_wide
      assign next_entry = {cur_entry[ENTRY_W-1:CNT_W], next_cnt};
    end else begin : g_narrow
      assign next_entry = next_cnt;
    end
  endgenerate

  assign rd_data = rd_in ? mem[rd_a] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (dec_done) mem[dec_a] <= next_entry;
      if (wr_ok)    mem[wr_a]  <= wr_data;
    end
  end

  // R7/R9: an accepted write is what the entry holds afterwards
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> mem[$past(wr_a)] == $past(wr_data));
  // R5: a clamped decrement leaves the count at zero
  a_r5_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sat |=> mem[$past(dec_a)][CNT_W-1:0] == '0);
  // R5: a decrement never raises the count
  a_r5_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> next_cnt <= cur_cnt);
endmodule

// File: rtl/crr_credit_release.sv
module crr_credit_release
  import crr_pkg::*;
#(
  parameter int BKT_DEPTH  = 256,
  parameter int RING_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rel_valid,
  input  logic [28:3] rel_addr,
  input  logic [15:0] rel_count,
  input  logic        tbl_valid,
  input  logic        tbl_write,
  input  logic [1:0]  tbl_sel,
  input  logic [12:0] tbl_idx,
  input  logic [31:0] tbl_wdata,
  output logic [31:0] tbl_rdata,
  output logic        tbl_rvalid,
  output logic        bkt_underflow,
  output logic        ring_underflow
);
  rel_cmd_t             cmd;
  logic                 bkt_wr, ring_wr, rd_req;
  logic                 bkt_done, bkt_sat, ring_done, ring_sat;
  logic [ENTRY_W-1:0]   bkt_rd;
  logic [CNT_W-1:0]     ring_rd;
  logic [TBL_IDX_W-1:0] ring_dec_idx;

  crr_rel_decode u_dec (
    .clk(clk), .rst_n(rst_n), .rel_valid(rel_valid), .rel_addr(rel_addr), .cmd(cmd)
  );

  assign bkt_wr       = tbl_valid & tbl_write & (tbl_sel == SEL_BUCKET);
  assign ring_wr      = tbl_valid & tbl_write & (tbl_sel == SEL_RING);
  assign rd_req       = tbl_valid & ~tbl_write;
  assign ring_dec_idx = TBL_IDX_W'(cmd.ring_idx);

  crr_count_bank #(.DEPTH(BKT_DEPTH), .IDX_W(TBL_IDX_W), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)) u_bkt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bkt_wr), .wr_idx(tbl_idx), .wr_data(tbl_wdata),
    .dec_req(cmd.bkt_req), .dec_idx(cmd.bkt_idx), .dec_amt(rel_count),
    .rd_idx(tbl_idx), .rd_data(bkt_rd),
    .dec_done(bkt_done), .dec_sat(bkt_sat)
  );

  crr_count_bank #(.DEPTH(RING_DEPTH), .IDX_W(TBL_IDX_W), .ENTRY_W(CNT_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ring_wr), .wr_idx(tbl_idx), .wr_data(tbl_wdata[CNT_W-1:0]),
    .dec_req(cmd.ring_req), .dec_idx(ring_dec_idx), .dec_amt(rel_count),
    .rd_idx(tbl_idx), .rd_data(ring_rd),
    .dec_done(ring_done), .dec_sat(ring_sat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_rdata      <= '0;
      tbl_rvalid     <= 1'b0;
      bkt_underflow  <= 1'b0;
      ring_underflow <= 1'b0;
    end else begin
      tbl_rvalid <= rd_req;
      if (rd_req) begin
        case (tbl_sel)
          SEL_BUCKET: tbl_rdata <= bkt_rd;
          SEL_RING:   tbl_rdata <= 32'(ring_rd);
          default:    tbl_rdata <= '0;
        endcase
      end
      if (bkt_sat)  bkt_underflow  <= 1'b1;
      if (ring_sat) ring_underflow <= 1'b1;
    end
  end

  // R6: flags are sticky
  a_r6_bkt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bkt_underflow |=> bkt_underflow);
  a_r6_ring_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ring_underflow |=> ring_underflow);
  // R8: every read request is answered on the next cycle
  a_r8_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> tbl_rvalid);
  // R2: no decrement happens without a strobe
  a_r2_no_stray_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (bkt_done || ring_done) |-> rel_valid);
endmodule

// File: tb/sim_crr_credit_release.sv
module sim_crr_credit_release;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rel_valid = 1'b0;
  logic [28:3] rel_addr = '0;
  logic [15:0] rel_count = '0;
  logic        tbl_valid = 1'b0, tbl_write = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [12:0] tbl_idx = '0;
  logic [31:0] tbl_wdata = '0;
  logic [31:0] tbl_rdata;
  logic        tbl_rvalid, bkt_underflow, ring_underflow;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] m_bkt  [256];
  logic [15:0] m_ring [256];
  logic        m_bflag = 1'b0, m_rflag = 1'b0;

  crr_credit_release u0 (.*);

  always #2 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycles %0d expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] m_sub(input logic [15:0] c, input logic [15:0] a);
    if (a > c) return 16'd0;
    return c - a;
  endfunction

  // one cycle of stimulus; called at a negedge, returns at the next negedge
  task automatic step(input bit rv, input int region, input bit ren, input bit ben,
                      input int ridx, input int bidx, input int cnt,
                      input bit tv, input bit tw, input int tsel, input int tidx,
                      input logic [31:0] twd);
    logic [28:0] a;
    bit bw, rw;
    a = '0;
    a[28:26] = 3'(region); a[25] = ben; a[24] = ren;
    a[23:11] = 13'(bidx); a[10:3] = 8'(ridx);
    rel_valid = rv; rel_addr = a[28:3]; rel_count = 16'(cnt);
    tbl_valid = tv; tbl_write = tw; tbl_sel = 2'(tsel); tbl_idx = 13'(tidx); tbl_wdata = twd;
    bw = tv && tw && tsel == 0 && tidx < 256;
    rw = tv && tw && tsel == 1 && tidx < 256;
    if (rv && region == 4 && ben && bidx < 256 && !(bw && tidx == bidx)) begin
      if (cnt > m_bkt[bidx][15:0]) m_bflag = 1'b1;
      m_bkt[bidx][15:0] = m_sub(m_bkt[bidx][15:0], 16'(cnt));
    end
    if (rv && region == 4 && ren && !(rw && tidx == ridx)) begin
      if (cnt > m_ring[ridx]) m_rflag = 1'b1;
      m_ring[ridx] = m_sub(m_ring[ridx], 16'(cnt));
    end
    if (bw) m_bkt[tidx] = twd;
    if (rw) m_ring[tidx] = twd[15:0];
    @(negedge clk);
    rel_valid = 1'b0; tbl_valid = 1'b0; tbl_write = 1'b0;
  endtask

  task automatic rd(input int sel, input int idx, output logic [31:0] v);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, sel, idx, 32'h0);
    v = tbl_rdata;
    chk("R8 rvalid", 32'(tbl_rvalid), 32'd1);
  endtask

  task automatic rel(input int region, input bit ren, input bit ben,
                     input int ridx, input int bidx, input int cnt);
    step(1, region, ren, ben, ridx, bidx, cnt, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic wr(input int sel, input int idx, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, sel, idx, d);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin m_bkt[i] = '0; m_ring[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rvalid", 32'(tbl_rvalid), 32'd0);
    chk("R1 flags", {30'd0, bkt_underflow, ring_underflow}, 32'd0);
    rd(0, 5, v); chk("R1 bucket", v, 32'd0);
    rd(1, 9, v); chk("R1 ring", v, 32'd0);
    // R7 write and read back: mode 3, group 7, ring 9, count 100
    wr(0, 5, {3'd3, 5'd7, 8'd9, 16'd100});
    wr(1, 9, 32'd50);
    rd(0, 5, v); chk("R7 bucket write", v, {3'd3, 5'd7, 8'd9, 16'd100});
    rd(1, 9, v); chk("R7 ring write", v, 32'd50);
    // R2 wrong region
    rel(3, 1, 1, 9, 5, 10);
    rd(0, 5, v); chk("R2 region gate bucket", v[15:0], 32'd100);
    rd(1, 9, v); chk("R2 region gate ring", v, 32'd50);
    // R3 bucket only / ring only
    rel(4, 0, 1, 9, 5, 10);
    rd(0, 5, v); chk("R3 bucket only", v, {3'd3, 5'd7, 8'd9, 16'd90});
    rd(1, 9, v); chk("R3 ring untouched", v, 32'd50);
    rel(4, 1, 0, 9, 5, 5);
    rd(1, 9, v); chk("R3 ring only", v, 32'd45);
    rd(0, 5, v); chk("R3 bucket untouched", v[15:0], 32'd90);
    // R4 both and neither
    rel(4, 1, 1, 9, 5, 20);
    rd(0, 5, v); chk("R4 both bucket", v, {3'd3, 5'd7, 8'd9, 16'd70});
    rd(1, 9, v); chk("R4 both ring", v, 32'd25);
    rel(4, 0, 0, 9, 5, 3);
    rd(0, 5, v); chk("R4 neither bucket", v[15:0], 32'd70);
    rd(1, 9, v); chk("R4 neither ring", v, 32'd25);
    chk("R6 flags clear", {30'd0, bkt_underflow, ring_underflow}, 32'd0);
    // R5 R6 clamp
    rel(4, 0, 1, 9, 5, 71);
    rd(0, 5, v); chk("R5 clamp zero", v, {3'd3, 5'd7, 8'd9, 16'd0});
    chk("R6 bucket flag", 32'(bkt_underflow), 32'd1);
    chk("R6 ring flag stays", 32'(ring_underflow), 32'd0);
    // R9 write wins, ring still decremented
    step(1, 4, 1, 1, 9, 5, 5, 1, 1, 0, 5, 32'd40);
    rd(0, 5, v); chk("R9 write wins", v, 32'd40);
    rd(1, 9, v); chk("R9 other target", v, 32'd20);
    // R10 out of range bucket index 261 must not alias onto 5
    rel(4, 0, 1, 0, 261, 1);
    rd(0, 5, v); chk("R10 no alias", v, 32'd40);
    rd(0, 261, v); chk("R8 out of range read", v, 32'd0);
    // R7 other select ignored
    wr(2, 5, 32'hFFFF_FFFF);
    rd(2, 5, v); chk("R8 bad select read", v, 32'd0);
    rd(0, 5, v); chk("R7 bad select ignored", v, 32'd40);
    // R8 read returns the pre-edge value when a release hits on the same edge
    step(1, 4, 0, 1, 0, 5, 4, 1, 0, 0, 5, 32'h0);
    chk("R8 old value", tbl_rdata, 32'd40);
    rd(0, 5, v); chk("R8 new value", v, 32'd36);
    chk("R6 sticky", 32'(bkt_underflow), 32'd1);

    // random mix: R2 R3 R4 R5 R7 R9 against the model
    for (int it = 0; it < 400; it++) begin
      int b, r, ti, ts;
      b = (($urandom % 16) == 0) ? 256 + ($urandom % 8) : $urandom % 8;
      r = $urandom % 8;
      ti = $urandom % 8;
      ts = $urandom % 3;
      step($urandom % 4 != 0, ($urandom % 5 == 0) ? 2 : 4, $urandom % 2, $urandom % 2,
           r, b, $urandom % 24, $urandom % 3 == 0, 1, ts, ti,
           {$urandom % 8, 5'($urandom), 8'($urandom), 16'($urandom % 40)});
      rd(0, ti, v); chk("R3 R5 R9 random bucket", v, m_bkt[ti]);
      rd(1, r, v);  chk("R3 R5 R9 random ring", v, 32'(m_ring[r]));
      chk("R6 random flags", {30'd0, bkt_underflow, ring_underflow}, {30'd0, m_bflag, m_rflag});
    end
    summary();
  end
endmodule